// File: doc/BRIEF.md
# Interleaved Dual-Converter Capture Sequencer

This block drives two identical sampling converters that watch the same analog input, so that the pair together captures at twice the rate of one converter. It enables the first converter, counts a programmable number of conversion-clock ticks, and then enables the second. A conversion takes twelve ticks, so an offset of six ticks places the two sample streams exactly half a conversion apart. Each converter keeps converting back to back while it is enabled. The sequencer keeps each converter's results in a private staging store. It turns each converter off once that converter has delivered its fixed quota of results.

When both quotas are met, the sequencer copies the two staging stores into one 64-entry result buffer. The first converter's results go to even slots and the second converter's results go to odd slots, so reading the buffer in address order gives a single time-ordered stream. A global done flag then rises. A toggle output for each converter changes on every accepted result, so a scope or a bench can confirm that the two streams are evenly spaced. Each acquisition runs once per start request.

Top module: `ilv_capture_seq`

## Requirements
- R1: After reset, `cnv_run`, `cnv_tgl` and `acq_done` are all 0, and every result buffer slot reads 0.
- R2: A `start_req` seen while the sequencer is idle or done sets `cnv_run[0]` at the next clock edge.
- R3: `lag_ticks` is captured with the start. `cnv_run[1]` rises at the clock edge that consumes the lag_ticks-th `conv_tick` counted while only `cnv_run[0]` is high. If the captured value is 0, both run bits rise together. With the converter models used, the first result of converter 1 therefore lands `lag_ticks` ticks after the first result of converter 0.
- R4: A result is accepted only on a cycle where `cnv_done[i]` and `cnv_run[i]` are both high. `cnv_run[i]` falls at the edge that accepts the 32nd result, and any `cnv_done[i]` pulse seen while `cnv_run[i]` is low has no effect.
- R5: `cnv_tgl[i]` inverts at the edge that accepts each result of converter i, which gives exactly 32 changes per acquisition.
- R6: `rd_data` shows buffer slot `rd_addr` with no clock delay. Slot 2k holds the k-th result of converter 0 and slot 2k+1 holds the k-th result of converter 1, with k counted from 0.
- R7: `acq_done` rises 65 clock cycles after the edge that accepts the final result of the later-finishing converter. It stays high until the next start is accepted, and at that point both run bits are low.
- R8: A `start_req` that arrives during the offset wait, the capture or the merge is ignored. The offset, the result counts and the buffer contents are unaffected.
- R9: A start accepted while done clears `acq_done` and both write pointers at the next edge. The new acquisition then overwrites the whole buffer.
- R10: Each staging write pointer advances by one per accepted result and never goes above 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Request to begin one acquisition |
| lag_ticks | input | LAG_W | Offset, in conversion ticks, between the two converter enables |
| conv_tick | input | 1 | One-cycle pulse per conversion-clock period |
| cnv_run | output | 2 | Enable to each converter; a converter converts continuously while its bit is high |
| cnv_done | input | 2 | One-cycle result-valid pulse from each converter |
| cnv_data0 | input | RES_W | Result from converter 0 |
| cnv_data1 | input | RES_W | Result from converter 1 |
| cnv_tgl | output | 2 | Per-converter strobe that toggles on every accepted result |
| acq_done | output | 1 | Acquisition complete and buffer merged |
| rd_addr | input | log2(2*PER_CH) | Result buffer read address |
| rd_data | output | RES_W | Result buffer read data |

## Verification
The enable of converter 0 is due one edge after the start. The enable of converter 1 is due at the edge that consumes the lag-th tick. Every toggle is due at the edge that accepts its result, and the done flag is due 65 edges after the last accepted result. The bench drives its inputs and samples the outputs at falling edges, and it timestamps each output change with a falling-edge cycle counter. The timing checks compare those timestamp differences with exact values: tick count to the second enable, toggle spacing equal to four cycles per lag tick, and 65 cycles to done. The bench never polls for a value loosely.

// File: rtl/ilv_pkg.sv
// Package: shared types for the interleaved capture sequencer.
// Assumes nothing beyond standard SystemVerilog.
package ilv_pkg;
    // Top-level sequence phases
    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_LAG,
        SEQ_CAPT,
        SEQ_MERGE,
        SEQ_DONE
    } seq_state_t;
endpackage

// File: rtl/ilv_lag_timer.sv
// Module: ilv_lag_timer
// Counts conversion ticks after the first converter is enabled and fires
// on the tick that completes the programmed offset.
// Assumes: load is a single-cycle pulse; a zero offset is handled by the caller.
module ilv_lag_timer #(
    parameter int LAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             count_en,
    input  logic             tick,
    input  logic [LAG_W-1:0] lag_in,
    output logic             fire
);
    logic [LAG_W-1:0] lag_q;
    logic [LAG_W-1:0] cnt_q;

    // Capture the offset at start and count ticks during the wait
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lag_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            lag_q <= lag_in;
            cnt_q <= '0;
        end else if (count_en && tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Fire on the tick that brings the count up to the offset
    always_comb begin
        fire = count_en && tick && (({1'b0, cnt_q} + 1'b1) == {1'b0, lag_q});
    end
endmodule

// File: rtl/ilv_stage_chan.sv
// Module: ilv_stage_chan
// One capture channel. It holds a converter enable, stores accepted results
// in a private staging store, toggles a strobe per result, and drops the
// enable after the quota is met.
// Assumes: arm and clr are single-cycle pulses; arm wins over clr.
module ilv_stage_chan #(
    parameter  int RES_W  = 10,
    parameter  int PER_CH = 32,
    localparam int PTR_W  = $clog2(PER_CH + 1),
    localparam int IDX_W  = $clog2(PER_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             arm,
    input  logic             cnv_done,
    input  logic [RES_W-1:0] cnv_data,
    output logic             run,
    output logic             tgl,
    output logic             full,
    output logic [PTR_W-1:0] ptr,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [RES_W-1:0] rd_val
);
    localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(PER_CH);

    logic             run_q;
    logic             tgl_q;
    logic             full_q;
    logic [PTR_W-1:0] ptr_q;
    logic [RES_W-1:0] mem_q [PER_CH];
    logic             accept;

    // A result counts only while enabled and below quota
    always_comb begin
        accept = run_q && cnv_done && (ptr_q < PTR_MAX);
    end

    // Enable, pointer, strobe and quota tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            tgl_q  <= 1'b0;
            full_q <= 1'b0;
            ptr_q  <= '0;
        end else if (arm) begin
            run_q  <= 1'b1;
            full_q <= 1'b0;
            ptr_q  <= '0;
        end else if (clr) begin
            run_q  <= 1'b0;
            full_q <= 1'b0;
            ptr_q  <= '0;
        end else if (accept) begin
            ptr_q <= ptr_q + 1'b1;
            tgl_q <= ~tgl_q;
            if (ptr_q == PTR_MAX - 1'b1) begin
                run_q  <= 1'b0;
                full_q <= 1'b1;
            end
        end
    end

    // Staging store write
    always_ff @(posedge clk) begin
        if (accept) begin
            mem_q[ptr_q[IDX_W-1:0]] <= cnv_data;
        end
    end

    assign run    = run_q;
    assign tgl    = tgl_q;
    assign full   = full_q;
    assign ptr    = ptr_q;
    assign rd_val = mem_q[rd_idx];
endmodule

// File: rtl/ilv_merge_buf.sv
// Module: ilv_merge_buf
// Result buffer. While go is high it walks every slot once, one per cycle,
// taking even slots from the first stream and odd slots from the second.
// Assumes: go stays high until last has been seen.
module ilv_merge_buf #(
    parameter  int RES_W  = 10,
    parameter  int PER_CH = 32,
    localparam int BUF_N  = 2 * PER_CH,
    localparam int ADDR_W = $clog2(BUF_N),
    localparam int IDX_W  = $clog2(PER_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [RES_W-1:0]  even_val,
    input  logic [RES_W-1:0]  odd_val,
    output logic [IDX_W-1:0]  src_idx,
    output logic              last,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [RES_W-1:0]  rd_data
);
    localparam logic [ADDR_W-1:0] SLOT_END = ADDR_W'(BUF_N - 1);

    logic [ADDR_W-1:0] cnt_q;
    logic [RES_W-1:0]  res_q [BUF_N];

    // Merge slot counter, held at zero outside the merge
    always_ff @(posedge clk) begin
        if (!rst_n || !go) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Buffer fill, alternating between the two sources
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < BUF_N; k++) begin
                res_q[k] <= '0;
            end
        end else if (go) begin
            res_q[cnt_q] <= cnt_q[0] ? odd_val : even_val;
        end
    end

    // Source index and end-of-merge flag
    always_comb begin
        src_idx = cnt_q[ADDR_W-1:1];
        last    = go && (cnt_q == SLOT_END);
    end

    assign rd_data = res_q[rd_addr];
endmodule

// File: rtl/ilv_capture_seq.sv
// Module: ilv_capture_seq (top)
// Sequences two interleaved converters. It enables the first converter,
// waits a programmed tick offset, enables the second, waits for both quotas
// to fill, then merges the results even/odd into the result buffer.
// Assumes: the offset is shorter than one full acquisition of converter 0.
module ilv_capture_seq #(
    parameter  int RES_W  = 10,
    parameter  int PER_CH = 32,
    parameter  int LAG_W  = 8,
    localparam int ADDR_W = $clog2(2 * PER_CH),
    localparam int PTR_W  = $clog2(PER_CH + 1),
    localparam int IDX_W  = $clog2(PER_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic [LAG_W-1:0]  lag_ticks,
    input  logic              conv_tick,
    output logic [1:0]        cnv_run,
    input  logic [1:0]        cnv_done,
    input  logic [RES_W-1:0]  cnv_data0,
    input  logic [RES_W-1:0]  cnv_data1,
    output logic [1:0]        cnv_tgl,
    output logic              acq_done,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [RES_W-1:0]  rd_data
);
    import ilv_pkg::*;

    seq_state_t       state_q, state_d;
    logic [1:0]       arm;
    logic             clr;
    logic             load;
    logic             fire;
    logic             merge_last;
    logic [1:0]       full;
    logic [IDX_W-1:0] src_idx;
    logic [RES_W-1:0] data_in  [2];
    logic [RES_W-1:0] stage_rd [2];
    logic [PTR_W-1:0] chan_ptr [2];

    assign data_in[0] = cnv_data0;
    assign data_in[1] = cnv_data1;

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next phase and channel control pulses
    always_comb begin
        state_d = state_q;
        arm     = 2'b00;
        clr     = 1'b0;
        load    = 1'b0;
        case (state_q)
            SEQ_IDLE, SEQ_DONE: begin
                if (start_req) begin
                    clr    = 1'b1;
                    load   = 1'b1;
                    arm[0] = 1'b1;
                    if (lag_ticks == '0) begin
                        arm[1]  = 1'b1;
                        state_d = SEQ_CAPT;
                    end else begin
                        state_d = SEQ_LAG;
                    end
                end
            end
            SEQ_LAG: begin
                if (fire) begin
                    arm[1]  = 1'b1;
                    state_d = SEQ_CAPT;
                end
            end
            SEQ_CAPT: begin
                if (&full) begin
                    state_d = SEQ_MERGE;
                end
            end
            SEQ_MERGE: begin
                if (merge_last) begin
                    state_d = SEQ_DONE;
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    ilv_lag_timer #(.LAG_W(LAG_W)) u_lag (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .count_en (state_q == SEQ_LAG),
        .tick     (conv_tick),
        .lag_in   (lag_ticks),
        .fire     (fire)
    );

    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
        ilv_stage_chan #(.RES_W(RES_W), .PER_CH(PER_CH)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr),
            .arm      (arm[ch]),
            .cnv_done (cnv_done[ch]),
            .cnv_data (data_in[ch]),
            .run      (cnv_run[ch]),
            .tgl      (cnv_tgl[ch]),
            .full     (full[ch]),
            .ptr      (chan_ptr[ch]),
            .rd_idx   (src_idx),
            .rd_val   (stage_rd[ch])
        );
    end

    ilv_merge_buf #(.RES_W(RES_W), .PER_CH(PER_CH)) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (state_q == SEQ_MERGE),
        .even_val (stage_rd[0]),
        .odd_val  (stage_rd[1]),
        .src_idx  (src_idx),
        .last     (merge_last),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    assign acq_done = (state_q == SEQ_DONE);
endmodule

// File: rtl/ilv_capture_chk.sv
// Module: ilv_capture_chk
// Timing and bound properties of the capture sequencer, bound to the top.
module ilv_capture_chk #(
    parameter int PER_CH = 32,
    parameter int PTR_W  = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_req,
    input logic [1:0]       cnv_run,
    input logic [1:0]       cnv_tgl,
    input logic             acq_done,
    input logic [PTR_W-1:0] ptr0,
    input logic [PTR_W-1:0] ptr1
);
    // R2: converter 0 is enabled only in response to a start
    assert_run0_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv_run[0]) |-> $past(start_req));

    // R3: converter 1 never starts ahead of converter 0
    assert_lead_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv_run[1]) |-> cnv_run[0]);

    // R5: a strobe moves only for a converter that was enabled
    assert_tgl0_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnv_tgl[0]) |-> $past(cnv_run[0]));
    assert_tgl1_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnv_tgl[1]) |-> $past(cnv_run[1]));

    // R7: both converters are off whenever done is shown
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acq_done |-> (cnv_run == 2'b00));

    // R9: done only drops because of a start
    assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(acq_done) |-> $past(start_req));

    // R9: restarting from done clears both pointers
    assert_ptr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && acq_done) |=> (ptr0 == '0) && (ptr1 == '0));

    // R10: pointers saturate at the quota
    assert_ptr_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(ptr0) <= PER_CH) && (int'(ptr1) <= PER_CH));
endmodule

bind ilv_capture_seq ilv_capture_chk #(.PER_CH(PER_CH), .PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .cnv_run   (cnv_run),
    .cnv_tgl   (cnv_tgl),
    .acq_done  (acq_done),
    .ptr0      (chan_ptr[0]),
    .ptr1      (chan_ptr[1])
);

// File: tb/test_ilv_capture_seq.sv
`timescale 1ns/1ps
// Directed bench for ilv_capture_seq with behavioural converter models.
module test_ilv_capture_seq;
    localparam int RES_W = 10;
    localparam int PER_CH = 32;
    localparam int LAG_W = 8;
    localparam int ADDR_W = 6;
    localparam int TDIV = 4;
    localparam int CONV = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_req = 1'b0;
    logic [LAG_W-1:0]  lag_ticks = '0;
    logic              conv_tick = 1'b0;
    logic [1:0]        cnv_run;
    logic [1:0]        cnv_done = 2'b00;
    logic [RES_W-1:0]  cnv_data0 = '0;
    logic [RES_W-1:0]  cnv_data1 = '0;
    logic [1:0]        cnv_tgl;
    logic              acq_done;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [RES_W-1:0]  rd_data;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // monitor and model state
    int cyc = 0;
    int tdiv = 0;
    int lag_seen = 0;
    int tgl_cnt [2];
    int first_t [2];
    int last_t [2];
    int done_t = -1;
    int seq [2];
    int ph [2];
    int cur_salt = 0;
    bit stray_en = 0;
    logic [1:0] tgl_prev = 2'b00;

    ilv_capture_seq #(.RES_W(RES_W), .PER_CH(PER_CH), .LAG_W(LAG_W)) i_ilv_capture_seq (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .lag_ticks(lag_ticks),
        .conv_tick(conv_tick), .cnv_run(cnv_run), .cnv_done(cnv_done),
        .cnv_data0(cnv_data0), .cnv_data1(cnv_data1), .cnv_tgl(cnv_tgl),
        .acq_done(acq_done), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    function automatic logic [RES_W-1:0] smp(int salt, int ch, int k);
        return RES_W'((salt * 7 + ch * 300 + k * 13) & 1023);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Converter models and output monitor, all at the falling edge
    always @(negedge clk) begin
        cyc++;
        for (int i = 0; i < 2; i++) begin
            if (cnv_tgl[i] !== tgl_prev[i]) begin
                tgl_cnt[i]++;
                if (first_t[i] < 0) first_t[i] = cyc;
                last_t[i] = cyc;
            end
        end
        tgl_prev = cnv_tgl;
        if (acq_done === 1'b1 && done_t < 0) done_t = cyc;
        conv_tick = (tdiv == TDIV - 1);
        tdiv = (tdiv + 1) % TDIV;
        if (conv_tick && cnv_run[0] && !cnv_run[1]) lag_seen++;
        cnv_done = 2'b00;
        for (int i = 0; i < 2; i++) begin
            if (cnv_run[i] === 1'b1) begin
                if (conv_tick) begin
                    ph[i]++;
                    if (ph[i] == CONV) begin
                        ph[i] = 0;
                        cnv_done[i] = 1'b1;
                        if (i == 0) cnv_data0 = smp(cur_salt, 0, seq[0]);
                        else        cnv_data1 = smp(cur_salt, 1, seq[1]);
                        seq[i]++;
                    end
                end
            end else begin
                ph[i] = 0;
                if (stray_en && conv_tick) begin
                    cnv_done[i] = 1'b1;
                    if (i == 0) cnv_data0 = '1;
                    else        cnv_data1 = '1;
                end
            end
        end
    end

    // R1: reset state
    task automatic t_reset();
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        chk(cnv_run == 2'b00, "R1", "run after reset", cnv_run, 0);
        chk(cnv_tgl == 2'b00, "R1", "strobe after reset", cnv_tgl, 0);
        chk(acq_done == 1'b0, "R1", "done after reset", acq_done, 0);
        rd_addr = 6'd0; #1;
        chk(rd_data == '0, "R1", "slot 0 after reset", rd_data, 0);
        rd_addr = 6'd63; #1;
        chk(rd_data == '0, "R1", "slot 63 after reset", rd_data, 0);
    endtask

    // One full acquisition with timing and content checks (R2..R9)
    task automatic run_acq(int lag, int salt, bit busy_starts, bit stray);
        int later;
        @(negedge clk); #1;
        lag_seen = 0; done_t = -1; cur_salt = salt; stray_en = stray;
        for (int i = 0; i < 2; i++) begin
            tgl_cnt[i] = 0; first_t[i] = -1; last_t[i] = -1; seq[i] = 0;
        end
        lag_ticks = LAG_W'(lag);
        start_req = 1'b1;
        @(negedge clk); #1;
        start_req = 1'b0;
        chk(cnv_run[0] == 1'b1, "R2", "converter 0 enabled after start", cnv_run[0], 1);
        chk(acq_done == 1'b0, "R9", "done cleared by start", acq_done, 0);
        if (busy_starts) begin
            // R8: starts during offset wait and during capture are ignored
            repeat (20) @(negedge clk); #1;
            lag_ticks = LAG_W'(lag + 3); start_req = 1'b1;
            @(negedge clk); #1; start_req = 1'b0; lag_ticks = LAG_W'(lag);
            repeat (600) @(negedge clk); #1;
            start_req = 1'b1;
            @(negedge clk); #1; start_req = 1'b0;
            chk(acq_done == 1'b0, "R8", "no done during capture", acq_done, 0);
        end
        for (int n = 0; n < 8000 && done_t < 0; n++) @(negedge clk);
        #1;
        chk(done_t >= 0, "R7", "done reached", done_t, 1);
        chk(lag_seen == lag, "R3", "ticks before converter 1 enable", lag_seen, lag);
        chk(tgl_cnt[0] == PER_CH, "R5", "converter 0 strobe changes", tgl_cnt[0], PER_CH);
        chk(tgl_cnt[1] == PER_CH, "R5", "converter 1 strobe changes", tgl_cnt[1], PER_CH);
        chk(first_t[1] - first_t[0] == lag * TDIV, "R3", "first result spacing",
            first_t[1] - first_t[0], lag * TDIV);
        later = (last_t[0] > last_t[1]) ? last_t[0] : last_t[1];
        chk(done_t - later == 65, "R7", "cycles from last result to done", done_t - later, 65);
        chk(cnv_run == 2'b00, "R4", "both converters off after quota", cnv_run, 0);
        for (int k = 0; k < 2 * PER_CH; k++) begin
            logic [RES_W-1:0] exp_v;
            exp_v = smp(salt, k % 2, k / 2);
            rd_addr = ADDR_W'(k); #1;
            chk(rd_data == exp_v, (stray || busy_starts) ? "R4/R8 R6" : "R6",
                $sformatf("slot %0d", k), rd_data, exp_v);
        end
        stray_en = 0;
    endtask

    // R7: done holds with no new start
    task automatic t_done_hold();
        repeat (30) @(negedge clk); #1;
        chk(acq_done == 1'b1, "R7", "done holds while idle", acq_done, 1);
    endtask

    initial begin
        for (int i = 0; i < 2; i++) begin
            tgl_cnt[i] = 0; first_t[i] = -1; last_t[i] = -1; seq[i] = 0; ph[i] = 0;
        end
        t_reset();
        run_acq(6, 1, 0, 0);    // half-conversion offset
        t_done_hold();
        run_acq(0, 2, 0, 0);    // both start together; restart from done (R9)
        run_acq(11, 3, 1, 0);   // busy starts ignored (R8)
        run_acq(3, 4, 0, 1);    // stray result pulses while disabled (R4)
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #(10 * 150000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule